// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the software-visible register file of a simple LCD controller. A 32-bit bus writes and reads six word registers inside a 256-byte window. These are one control word, three timing words, one event status word and one subpanel word. The block decodes the stored words into the configuration fields that the rest of the controller uses: enable, monochrome, TFT, palette-loading mode, interrupt mask, active width and height, and the subpanel settings.

The pixel pipeline reports three events as single-cycle pulses: frame finished, palette loaded and sync error. The block latches each one into a sticky status bit, and software clears these bits by writing ones. All three sources combine into a single interrupt line. Frame and palette events reach it only when their mask bit is set. A sync error reaches it whatever the mask holds. A write that flips the enable bit produces a one-cycle restart pulse, which the frame sequencer uses to start over.

Read data is combinational from the address. Writes take effect at the clock edge on which `wr_en` is sampled high. Only word-aligned offsets are decoded.

Top module: `lcdc_regif`

## Requirements
- R1: A write to offset 0x00 sets the decoded outputs on the next edge as follows: `lcd_enable` from bit 0, `lcd_mono` from bit 1, `irq_mask` from bits 4:3, `lcd_tft` from bit 7 and `pal_mode` from bits 21:20.
- R2: Reading offset 0x00 returns the written word ANDed with 0x01FFF39B. The TFT bit is copied into bit 23, and the result is ORed with 0xFE000C34.
- R3: A write to offset 0x04 stores the whole word. `width` equals bits 9:0 plus one. A read returns the stored word ORed with 0x0000000F.
- R4: A write to offset 0x08 stores the whole word, and `height` equals bits 9:0 plus one. Offset 0x08 reads back unchanged. Offset 0x0C reads back ORed with 0xFC000000.
- R5: An event pulse sets its sticky status bit on the next edge. Offset 0x10 reads frame-done in bit 0, sync-error in bit 2 and palette-done in bit 6, with all other bits zero.
- R6: A write to offset 0x10 clears each status bit written as one, using bits 0, 2 and 6. If an event arrives on the same edge as its clear, the bit stays set.
- R7: `irq` is high while frame-done is latched and mask bit 0 is set, or while palette-done is latched and mask bit 1 is set.
- R8: A latched sync error drives `irq` high whatever the mask holds. With no latched status bit, `irq` is low.
- R9: `restart` is high for exactly the one cycle after an edge that wrote offset 0x00 with bit 0 different from the stored enable. It stays low for any other write.
- R10: A write to offset 0x14 stores the word ANDed with 0xA1FFFFFF, and that value reads back. The outputs are `sub_enable` = bit 31, `sub_from_line` = bit 29, `sub_line` = bits 25:16 and `sub_fill` = bits 15:0.
- R11: Offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 read as zero, and writes to them change no register.
- R12: While `rst` is high on an edge, every register and status bit clears. Control then reads 0xFE000C34, timing 0 reads 0x0000000F, width and height are 1, and `irq` and `restart` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 8 | Byte offset in the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| frame_done_evt | input | 1 | Frame finished pulse |
| palette_done_evt | input | 1 | Palette loaded pulse |
| sync_err_evt | input | 1 | Sync error pulse |
| irq | output | 1 | Combined interrupt line |
| restart | output | 1 | One-cycle pulse on an enable change |
| lcd_enable | output | 1 | Controller enable |
| lcd_mono | output | 1 | Monochrome mode |
| lcd_tft | output | 1 | TFT panel mode |
| pal_mode | output | 2 | Palette-loading mode |
| irq_mask | output | 2 | Frame (bit 0) and palette (bit 1) interrupt mask |
| width | output | 11 | Active width in pixels |
| height | output | 11 | Active height in lines |
| sub_enable | output | 1 | Subpanel active |
| sub_from_line | output | 1 | Subpanel starts at `sub_line` |
| sub_line | output | 10 | Subpanel line boundary |
| sub_fill | output | 16 | Subpanel fill data |

## Verification
Each result has a fixed due cycle. Register contents, decoded fields and read-back are due on the cycle after the write edge. Status bits and `irq` follow one edge after an event pulse. `restart` is high only in the single cycle after the write edge. `rdata` follows `addr` without any edge. The bench drives every input on the falling edge and compares one nanosecond later. Each comparison therefore falls in exactly the cycle in which the result is due, and the `restart` check is repeated one cycle later to confirm that the pulse has ended.

// File: rtl/lcdc_regif_pkg.sv
package lcdc_regif_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int DIM_W  = 10;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_TIM0 = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_TIM1 = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_TIM2 = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_SUB  = 8'h14;

    // writable control bits: named fields plus the kept extra bits
    localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h01CF_F300 | 32'h0030_009B;
    localparam logic [DATA_W-1:0] CTRL_RO1   = 32'hFE00_0C34;
    localparam logic [DATA_W-1:0] TIM0_RO1   = 32'h0000_000F;
    localparam logic [DATA_W-1:0] TIM2_RO1   = 32'hFC00_0000;
    localparam logic [DATA_W-1:0] SUB_WMASK  = 32'hA1FF_FFFF;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CTRL, SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_STAT, SEL_SUB
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] pal_mode;
        logic       tft;
        logic [1:0] irq_mask;
        logic       mono;
        logic       enable;
    } ctrl_fields_t;

    typedef struct packed {
        logic pal;
        logic sync;
        logic frame;
    } evt_t;

    function automatic reg_sel_e addr_decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CTRL: return SEL_CTRL;
            OFS_TIM0: return SEL_TIM0;
            OFS_TIM1: return SEL_TIM1;
            OFS_TIM2: return SEL_TIM2;
            OFS_STAT: return SEL_STAT;
            OFS_SUB:  return SEL_SUB;
            default:  return SEL_NONE;
        endcase
    endfunction

    function automatic ctrl_fields_t ctrl_decode(input logic [DATA_W-1:0] w);
        ctrl_fields_t f;
        f.enable   = w[0];
        f.mono     = w[1];
        f.irq_mask = w[4:3];
        f.tft      = w[7];
        f.pal_mode = w[21:20];
        return f;
    endfunction

    function automatic evt_t status_bits(input logic [DATA_W-1:0] w);
        evt_t e;
        e.frame = w[0];
        e.sync  = w[2];
        e.pal   = w[6];
        return e;
    endfunction

endpackage

// File: rtl/lcdc_cfg_regs.sv
module lcdc_cfg_regs
    import lcdc_regif_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int DMW = DIM_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  reg_sel_e       sel,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  ctrl_q,
    output logic [DW-1:0]  tim0_q,
    output logic [DW-1:0]  tim1_q,
    output logic [DW-1:0]  tim2_q,
    output logic [DW-1:0]  sub_q,
    output ctrl_fields_t   fields,
    output logic [DMW:0]   width,
    output logic [DMW:0]   height,
    output logic           restart
);
    localparam int SZW = DMW + 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            tim0_q  <= '0;
            tim1_q  <= '0;
            tim2_q  <= '0;
            sub_q   <= '0;
            restart <= 1'b0;
        end else begin
            restart <= wr_en && (sel == SEL_CTRL) && (wdata[0] != ctrl_q[0]);
            if (wr_en) begin
                case (sel)
                    SEL_CTRL: ctrl_q <= wdata & CTRL_WMASK;
                    SEL_TIM0: tim0_q <= wdata;
                    SEL_TIM1: tim1_q <= wdata;
                    SEL_TIM2: tim2_q <= wdata;
                    SEL_SUB:  sub_q  <= wdata & SUB_WMASK;
                    default:  ;
                endcase
            end
        end
    end

    assign fields = ctrl_decode(ctrl_q);
    assign width  = SZW'(tim0_q[DMW-1:0]) + SZW'(1);
    assign height = SZW'(tim1_q[DMW-1:0]) + SZW'(1);

    // R9: a pulse only follows an actual flip of the enable bit
    assert_restart_flip_R9: assert property (@(posedge clk) disable iff (rst)
        restart |-> (fields.enable != $past(fields.enable)));
    // R9: no pulse without a write in the previous cycle
    assert_restart_needs_write_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> !restart);
    // R3, R11: width holds while nothing is written
    assert_width_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> $stable(width));
endmodule

// File: rtl/lcdc_evt_status.sv
module lcdc_evt_status
    import lcdc_regif_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_en,
    input  evt_t       clr_bits,
    input  evt_t       evt,
    input  logic [1:0] irq_mask,
    output evt_t       status,
    output logic       irq
);
    evt_t clr_eff;

    assign clr_eff = clr_en ? clr_bits : '0;

    // events win over a clear on the same edge
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_eff) | evt;
    end

    assign irq = (status.frame & irq_mask[0])
               | (status.pal   & irq_mask[1])
               |  status.sync;

    assert_frame_latch_R5: assert property (@(posedge clk) disable iff (rst)
        evt.frame |=> status.frame);
    assert_clear_frame_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_en && clr_bits.frame && !evt.frame) |=> !status.frame);
    assert_sync_irq_R8: assert property (@(posedge clk) disable iff (rst)
        evt.sync |=> irq);
endmodule

// File: rtl/lcdc_rd_mux.sv
module lcdc_rd_mux
    import lcdc_regif_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  reg_sel_e      sel,
    input  logic [DW-1:0] ctrl_q,
    input  logic [DW-1:0] tim0_q,
    input  logic [DW-1:0] tim1_q,
    input  logic [DW-1:0] tim2_q,
    input  logic [DW-1:0] sub_q,
    input  evt_t          status,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] tft_mirror;
    logic [DW-1:0] stat_word;

    always_comb begin
        tft_mirror     = '0;
        tft_mirror[23] = ctrl_q[7];
        stat_word      = '0;
        stat_word[0]   = status.frame;
        stat_word[2]   = status.sync;
        stat_word[6]   = status.pal;
    end

    always_comb begin
        case (sel)
            SEL_CTRL: rdata = ctrl_q | tft_mirror | CTRL_RO1;
            SEL_TIM0: rdata = tim0_q | TIM0_RO1;
            SEL_TIM1: rdata = tim1_q;
            SEL_TIM2: rdata = tim2_q | TIM2_RO1;
            SEL_STAT: rdata = stat_word;
            SEL_SUB:  rdata = sub_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/lcdc_regif.sv
module lcdc_regif
    import lcdc_regif_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               frame_done_evt,
    input  logic               palette_done_evt,
    input  logic               sync_err_evt,
    output logic               irq,
    output logic               restart,
    output logic               lcd_enable,
    output logic               lcd_mono,
    output logic               lcd_tft,
    output logic [1:0]         pal_mode,
    output logic [1:0]         irq_mask,
    output logic [DIM_W:0]     width,
    output logic [DIM_W:0]     height,
    output logic               sub_enable,
    output logic               sub_from_line,
    output logic [9:0]         sub_line,
    output logic [15:0]        sub_fill
);
    reg_sel_e          sel;
    ctrl_fields_t      fields;
    evt_t              evt, status;
    logic [DATA_W-1:0] ctrl_q, tim0_q, tim1_q, tim2_q, sub_q;

    assign sel = addr_decode(addr);
    assign evt = '{pal: palette_done_evt, sync: sync_err_evt, frame: frame_done_evt};

    lcdc_cfg_regs #(.DW(DATA_W), .DMW(DIM_W)) cfg_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wdata(wdata),
        .ctrl_q(ctrl_q), .tim0_q(tim0_q), .tim1_q(tim1_q), .tim2_q(tim2_q),
        .sub_q(sub_q), .fields(fields), .width(width), .height(height),
        .restart(restart)
    );

    lcdc_evt_status stat_i (
        .clk(clk), .rst(rst),
        .clr_en(wr_en && (sel == SEL_STAT)), .clr_bits(status_bits(wdata)),
        .evt(evt), .irq_mask(fields.irq_mask), .status(status), .irq(irq)
    );

    lcdc_rd_mux #(.DW(DATA_W)) rd_i (
        .sel(sel), .ctrl_q(ctrl_q), .tim0_q(tim0_q), .tim1_q(tim1_q),
        .tim2_q(tim2_q), .sub_q(sub_q), .status(status), .rdata(rdata)
    );

    assign lcd_enable    = fields.enable;
    assign lcd_mono      = fields.mono;
    assign lcd_tft       = fields.tft;
    assign pal_mode      = fields.pal_mode;
    assign irq_mask      = fields.irq_mask;
    assign sub_enable    = sub_q[31];
    assign sub_from_line = sub_q[29];
    assign sub_line      = sub_q[25:16];
    assign sub_fill      = sub_q[15:0];

    // R7: a masked-off frame event alone never raises the line
    assert_frame_masked_R7: assert property (@(posedge clk) disable iff (rst)
        (status.frame && !status.pal && !status.sync && !irq_mask[0]) |-> !irq);
    // R12: reset leaves the interrupt line low
    assert_reset_quiet_R12: assert property (@(posedge clk)
        $past(rst) |-> (!irq && !restart));
endmodule

// File: tb/lcdc_regif_tb.sv
`timescale 1ns/1ps
module lcdc_regif_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        f_evt = 1'b0, p_evt = 1'b0, s_evt = 1'b0;
    logic        irq, restart, lcd_enable, lcd_mono, lcd_tft;
    logic [1:0]  pal_mode, irq_mask;
    logic [10:0] width, height;
    logic        sub_enable, sub_from_line;
    logic [9:0]  sub_line;
    logic [15:0] sub_fill;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lcdc_regif dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .frame_done_evt(f_evt), .palette_done_evt(p_evt),
        .sync_err_evt(s_evt), .irq(irq), .restart(restart),
        .lcd_enable(lcd_enable), .lcd_mono(lcd_mono), .lcd_tft(lcd_tft),
        .pal_mode(pal_mode), .irq_mask(irq_mask), .width(width), .height(height),
        .sub_enable(sub_enable), .sub_from_line(sub_from_line),
        .sub_line(sub_line), .sub_fill(sub_fill)
    );

    // {offset, write value, expected read-back}
    localparam int NV = 10;
    localparam logic [71:0] VEC [NV] = '{
        {8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFBF},  // R2
        {8'h00, 32'h0000_0000, 32'hFE00_0C34},  // R2
        {8'h00, 32'h0010_0842, 32'hFE10_0C36},  // R2
        {8'h04, 32'h1234_5678, 32'h1234_567F},  // R3
        {8'h08, 32'hABCD_E3FF, 32'hABCD_E3FF},  // R4
        {8'h0C, 32'h0000_1234, 32'hFC00_1234},  // R4
        {8'h14, 32'hFFFF_FFFF, 32'hA1FF_FFFF},  // R10
        {8'h18, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
        {8'hFC, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
        {8'h10, 32'h0000_0045, 32'h0000_0000}   // R6
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic pulse(input logic f, input logic p, input logic s);
        @(negedge clk);
        f_evt = f; p_evt = p; s_evt = s;
        @(negedge clk);
        f_evt = 1'b0; p_evt = 1'b0; s_evt = 1'b0;
        #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R12: reset state
        rd(8'h00, 32'hFE00_0C34, "R12 ctrl after reset");
        rd(8'h04, 32'h0000_000F, "R12 tim0 after reset");
        rd(8'h10, 32'h0000_0000, "R12 status after reset");
        chk("R12 width", 32'(width), 32'd1);
        chk("R12 height", 32'(height), 32'd1);
        chk("R12 irq", 32'(irq), 32'd0);
        chk("R12 restart", 32'(restart), 32'd0);

        // table walk: write then read back
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], VEC[i][31:0], $sformatf("R2/R3/R4/R10/R11/R6 vec %0d", i));
        end
        // R11: undecoded writes left earlier registers alone
        rd(8'h14, 32'hA1FF_FFFF, "R11 sub intact");
        rd(8'h00, 32'hFE10_0C36, "R11 ctrl intact");

        // R1 and R9: field decode and restart pulse
        wr(8'h00, 32'h0030_0099);
        chk("R9 restart on flip", 32'(restart), 32'd1);
        chk("R1 fields", {25'd0, pal_mode, lcd_tft, irq_mask, lcd_mono, lcd_enable},
            {25'd0, 2'd3, 1'b1, 2'd3, 1'b0, 1'b1});
        @(negedge clk); #1;
        chk("R9 restart one cycle", 32'(restart), 32'd0);
        wr(8'h00, 32'h0000_0003);
        chk("R9 no restart same enable", 32'(restart), 32'd0);
        chk("R1 mono/mask", {28'd0, irq_mask, lcd_mono, lcd_tft}, {28'd0, 2'd0, 1'b1, 1'b0});

        // R3, R4: dimension outputs
        chk("R3 width", 32'(width), 32'd633);
        chk("R4 height", 32'(height), 32'd1024);

        // R10: subpanel outputs
        wr(8'h14, 32'hFFFF_FFFF);
        chk("R10 sub fields all", {sub_enable, sub_from_line, 4'd0, sub_line, sub_fill},
            {1'b1, 1'b1, 4'd0, 10'h1FF, 16'hFFFF});
        wr(8'h14, 32'h0005_1234);
        chk("R10 sub fields", {sub_enable, sub_from_line, 4'd0, sub_line, sub_fill},
            {1'b0, 1'b0, 4'd0, 10'd5, 16'h1234});

        // R5, R7: frame event masked then unmasked
        wr(8'h00, 32'h0000_0001);
        pulse(1'b1, 1'b0, 1'b0);
        rd(8'h10, 32'h0000_0001, "R5 frame latched");
        chk("R7 frame masked", 32'(irq), 32'd0);
        wr(8'h00, 32'h0000_0009);
        #1;
        chk("R7 frame unmasked", 32'(irq), 32'd1);
        wr(8'h10, 32'h0000_0001);
        rd(8'h10, 32'h0000_0000, "R6 clear frame");
        chk("R6 irq after clear", 32'(irq), 32'd0);

        // R5, R7: palette event
        pulse(1'b0, 1'b1, 1'b0);
        rd(8'h10, 32'h0000_0040, "R5 palette latched");
        chk("R7 palette wrong mask", 32'(irq), 32'd0);
        wr(8'h00, 32'h0000_0011);
        #1;
        chk("R7 palette unmasked", 32'(irq), 32'd1);
        wr(8'h10, 32'h0000_0040);
        rd(8'h10, 32'h0000_0000, "R6 clear palette");

        // R8: sync error ignores mask
        wr(8'h00, 32'h0000_0001);
        pulse(1'b0, 1'b0, 1'b1);
        rd(8'h10, 32'h0000_0004, "R5 sync latched");
        chk("R8 sync irq mask 0", 32'(irq), 32'd1);

        // R6: event on the same edge as its clear keeps the bit
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h10; wdata = 32'h0000_0004; s_evt = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; s_evt = 1'b0;
        rd(8'h10, 32'h0000_0004, "R6 event beats clear");
        wr(8'h10, 32'h0000_0004);
        rd(8'h10, 32'h0000_0000, "R6 sync cleared");
        chk("R8 irq low when idle", 32'(irq), 32'd0);

        // R12: reset mid-run
        wr(8'h00, 32'h0000_0009);
        pulse(1'b1, 1'b0, 1'b1);
        chk("R7 irq before reset", 32'(irq), 32'd1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk("R12 irq in reset", 32'(irq), 32'd0);
        rd(8'h10, 32'h0000_0000, "R12 status in reset");
        rd(8'h00, 32'hFE00_0C34, "R12 ctrl in reset");
        rd(8'h14, 32'h0000_0000, "R12 sub in reset");
        rst = 1'b0;

        summary();
        $finish;
    end
endmodule